// File: doc/BRIEF.md
# Capture/Compare Timer Channel

This block is a free-running up-counter with two registers beside it. Each register works either as a capture register or as a compare register. The counter advances on a single-cycle count tick. That tick comes either from a prescaler tick or from an external tick, which is derived from the edge of trigger input 0. A stop/run control forces the counter to zero and holds it there. Register contents survive a stop.

In capture mode, a register watches its own trigger input. The input is an already-filtered level, sampled on each prescaler tick. A qualifying edge is accepted only once two consecutive samples show the new level. The counter value present during the accepting tick is then stored, and the register's interrupt pulses one prescaler tick later. Capture is suppressed in three cases:

- the register is in compare mode;
- both edges are selected;
- for register 0 only, the counter is being clocked by the external tick.

In compare mode, a register raises a one-cycle interrupt when a count tick meets an equal counter value. If clear is enabled, a match on register 0 also returns the counter to zero in place of the increment. Software loads either register through a write strobe.

Top module: `ccap_timer`

## Requirements
- R1: After reset the counter, both registers and both interrupt outputs are zero.
- R2: While `run_i` is low the counter becomes zero on the next clock and stays there; register contents are kept.
- R3: While running, the counter adds one per selected tick, wrapping at its width. `src_ext_i`=1 selects `ext_tick_i`, 0 selects `presc_tick_i`, and the unselected tick has no effect.
- R4: Edge select per register, 2 bits at `edge_sel_i[2k+1:2k]`: 00 none, 01 rising, 10 falling, 11 both. Triggers are sampled on prescaler ticks. An edge is accepted at the tick whose sample and the previous sample both show the new level after an opposite-level sample. The counter value during that tick is latched.
- R5: A trigger pulse seen by only one prescaler sample is not captured.
- R6: A capture interrupt is a one-cycle pulse raised by the prescaler tick after the accepting tick, not by the accepting tick itself.
- R7: While `src_ext_i` is 1, register 0 takes no capture; register 1 still captures.
- R8: With edge select 11 the register takes no capture.
- R9: A register with `cmp_mode_i[k]`=1 ignores triggers and keeps its value.
- R10: In compare mode, a count tick while the counter equals the register gives a one-cycle pulse on that register's interrupt in the next cycle.
- R11: With `clr_en_i`=1, a register 0 compare match loads zero into the counter instead of incrementing; a register 1 match never clears.
- R12: `wr_en_i` loads `wr_data_i` into register `wr_sel_i` on the next edge and wins over a capture in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| run_i | input | 1 | 1 runs the counter, 0 holds it at zero |
| src_ext_i | input | 1 | Count source: 1 external tick, 0 prescaler tick |
| presc_tick_i | input | 1 | Prescaler tick, also the trigger sampling tick |
| ext_tick_i | input | 1 | External count tick (edge of trigger 0) |
| trig_i | input | 2 | Filtered trigger levels, one per register |
| edge_sel_i | input | 4 | Edge select, 2 bits per register |
| cmp_mode_i | input | 2 | 1 = compare mode, 0 = capture mode |
| clr_en_i | input | 1 | Clear counter on register 0 match |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Register index for a write |
| wr_data_i | input | 16 | Write data |
| cnt_o | output | 16 | Counter value |
| regs_o | output | 32 | Register contents, register 0 in the low half |
| irq_o | output | 2 | Per-register interrupt pulses |

## Verification
The capture path is driven with several trigger patterns:

- Rising and falling pulses on each register show that the latched value is the count at the second sample, not the first.
- One-sample pulses show that the two-sample rule drops short triggers.
- A both-edge selection, compare mode and the external count source each block capture. Running the external source against register 1 shows that this block is specific to register 0.

Compare sequences with clear on and off, and on each register, tell a clearing match from a plain match. A capture traced tick by tick separates the latch tick from the interrupt tick. A write landing on an accepting tick shows which of the two wins.

// File: rtl/ccap_pkg.sv
package ccap_pkg;
  typedef enum logic [1:0] {
    EDGE_NONE = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_sel_e;
endpackage

// File: rtl/ccap_edge_det.sv
// Two-sample edge qualifier: the new level must be seen on two
// consecutive sampling ticks after a sample of the opposite level.
module ccap_edge_det (
  input  logic clk,
  input  logic rst,
  input  logic smp_en,
  input  logic lvl,
  output logic rise_o,
  output logic fall_o
);
  logic [1:0] hist_q; // [0] newest sample, [1] the one before

  always_ff @(posedge clk) begin
    if (rst) hist_q <= 2'b00;
    else if (smp_en) hist_q <= {hist_q[0], lvl};
  end

  assign rise_o = smp_en &  lvl &  hist_q[0] & ~hist_q[1];
  assign fall_o = smp_en & ~lvl & ~hist_q[0] &  hist_q[1];
endmodule

// File: rtl/ccap_counter.sv
module ccap_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             tick,
  input  logic             clr_req,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk) begin
    if (rst || !run) cnt_o <= '0;
    else if (tick) cnt_o <= clr_req ? '0 : cnt_o + CNT_W'(1);
  end
endmodule

// File: rtl/ccap_chan.sv
module ccap_chan
  import ccap_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             smp_tick,
  input  logic             cnt_tick,
  input  logic             rise,
  input  logic             fall,
  input  edge_sel_e        sel,
  input  logic             cmp_mode,
  input  logic             src_block,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] reg_o,
  output logic             match_o,
  output logic             irq_o
);
  logic edge_ok, cap_ok, pend_q;

  // Both-edge selection falls through to no acceptance.
  always_comb begin
    unique case (sel)
      EDGE_RISE: edge_ok = rise;
      EDGE_FALL: edge_ok = fall;
      default:   edge_ok = 1'b0;
    endcase
  end

  assign cap_ok  = run & ~cmp_mode & ~src_block & edge_ok;
  assign match_o = run & cnt_tick & cmp_mode & (cnt_i == reg_o);

  always_ff @(posedge clk) begin
    if (rst) reg_o <= '0;
    else if (wr_en) reg_o <= wr_data;
    else if (cap_ok) reg_o <= cnt_i;
  end

  // Capture interrupt waits for the following sampling tick.
  always_ff @(posedge clk) begin
    if (rst || !run) begin
      pend_q <= 1'b0;
      irq_o  <= 1'b0;
    end else begin
      if (smp_tick) pend_q <= cap_ok;
      irq_o <= (smp_tick & pend_q) | match_o;
    end
  end
endmodule

// File: rtl/ccap_timer.sv
module ccap_timer
  import ccap_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int NUM_CH = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    run_i,
  input  logic                    src_ext_i,
  input  logic                    presc_tick_i,
  input  logic                    ext_tick_i,
  input  logic [NUM_CH-1:0]       trig_i,
  input  logic [2*NUM_CH-1:0]     edge_sel_i,
  input  logic [NUM_CH-1:0]       cmp_mode_i,
  input  logic                    clr_en_i,
  input  logic                    wr_en_i,
  input  logic [((NUM_CH>1)?$clog2(NUM_CH):1)-1:0] wr_sel_i,
  input  logic [CNT_W-1:0]        wr_data_i,
  output logic [CNT_W-1:0]        cnt_o,
  output logic [NUM_CH*CNT_W-1:0] regs_o,
  output logic [NUM_CH-1:0]       irq_o
);
  localparam int SEL_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  // Only register 0 may clear the counter.
  localparam logic [NUM_CH-1:0] CLR_MASK = NUM_CH'(1);

  logic              cnt_tick;
  logic              clr_req;
  logic [NUM_CH-1:0] match_w;

  assign cnt_tick = src_ext_i ? ext_tick_i : presc_tick_i;
  assign clr_req  = clr_en_i & |(match_w & CLR_MASK);

  ccap_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .run(run_i), .tick(cnt_tick),
    .clr_req(clr_req), .cnt_o(cnt_o)
  );

  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    logic rise_w, fall_w;
    // Trigger 0 doubles as the external count source.
    logic blk_w;
    assign blk_w = (k == 0) ? src_ext_i : 1'b0;

    ccap_edge_det u_edge (
      .clk(clk), .rst(rst), .smp_en(presc_tick_i), .lvl(trig_i[k]),
      .rise_o(rise_w), .fall_o(fall_w)
    );

    ccap_chan #(.CNT_W(CNT_W)) u_chan (
      .clk(clk), .rst(rst), .run(run_i), .cnt_i(cnt_o),
      .smp_tick(presc_tick_i), .cnt_tick(cnt_tick),
      .rise(rise_w), .fall(fall_w),
      .sel(edge_sel_e'(edge_sel_i[2*k +: 2])),
      .cmp_mode(cmp_mode_i[k]), .src_block(blk_w),
      .wr_en(wr_en_i && (wr_sel_i == SEL_W'(k))), .wr_data(wr_data_i),
      .reg_o(regs_o[k*CNT_W +: CNT_W]), .match_o(match_w[k]),
      .irq_o(irq_o[k])
    );
  end
endmodule

// File: rtl/ccap_timer_sva.sv
module ccap_timer_sva #(
  parameter int CNT_W  = 16,
  parameter int NUM_CH = 2
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    run_i,
  input logic                    src_ext_i,
  input logic                    presc_tick_i,
  input logic                    ext_tick_i,
  input logic [2*NUM_CH-1:0]     edge_sel_i,
  input logic [NUM_CH-1:0]       cmp_mode_i,
  input logic                    wr_en_i,
  input logic [((NUM_CH>1)?$clog2(NUM_CH):1)-1:0] wr_sel_i,
  input logic [CNT_W-1:0]        wr_data_i,
  input logic [CNT_W-1:0]        cnt_o,
  input logic [NUM_CH*CNT_W-1:0] regs_o,
  input logic [NUM_CH-1:0]       irq_o
);
  logic wr0, wr1;
  assign wr0 = wr_en_i && (wr_sel_i == '0);
  assign wr1 = wr_en_i && (wr_sel_i != '0);

  p_stop_zero_r2: assert property (@(posedge clk) disable iff (rst)
    !run_i |=> cnt_o == '0);

  p_no_tick_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (run_i && !(src_ext_i ? ext_tick_i : presc_tick_i)) |=> $stable(cnt_o));

  p_irq_on_tick_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_o[0]) |-> $past(presc_tick_i || ext_tick_i));

  p_ext_src_block_r7: assert property (@(posedge clk) disable iff (rst)
    (src_ext_i && !wr0) |=> regs_o[CNT_W-1:0] == $past(regs_o[CNT_W-1:0]));

  p_both_edge_block_r8: assert property (@(posedge clk) disable iff (rst)
    (edge_sel_i[1:0] == 2'b11 && !wr0) |=> regs_o[CNT_W-1:0] == $past(regs_o[CNT_W-1:0]));

  p_cmp_keeps_r9: assert property (@(posedge clk) disable iff (rst)
    (cmp_mode_i[1] && !wr1) |=> regs_o[2*CNT_W-1:CNT_W] == $past(regs_o[2*CNT_W-1:CNT_W]));

  p_write_wins_r12: assert property (@(posedge clk) disable iff (rst)
    wr0 |=> regs_o[CNT_W-1:0] == $past(wr_data_i));
endmodule

bind ccap_timer ccap_timer_sva #(.CNT_W(CNT_W), .NUM_CH(NUM_CH)) u_sva (.*);

// File: tb/ccap_timer_test.sv
module ccap_timer_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst = 1'b1;
  logic        run = 0, src_ext = 0, presc = 0, ext = 0, clr_en = 0;
  logic        wr_en = 0, wr_sel = 0;
  logic [15:0] wr_data = '0;
  logic [1:0]  trig = '0, cmp_mode = '0, irq;
  logic [3:0]  edge_sel = '0;
  logic [15:0] cnt;
  logic [31:0] regs;
  int          n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ccap_timer uut (
    .clk(clk), .rst(rst), .run_i(run), .src_ext_i(src_ext),
    .presc_tick_i(presc), .ext_tick_i(ext), .trig_i(trig),
    .edge_sel_i(edge_sel), .cmp_mode_i(cmp_mode), .clr_en_i(clr_en),
    .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
    .cnt_o(cnt), .regs_o(regs), .irq_o(irq)
  );

  typedef struct packed {
    logic        ch;
    logic [1:0]  edg;
    logic        cmp;
    logic        ext;
    logic [2:0]  plen;
    logic [15:0] expv;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 2'b01, 1'b0, 1'b0, 3'd2, 16'd6,      4'd4}, // R4 rising, reg 0
    '{1'b0, 2'b10, 1'b0, 1'b0, 3'd3, 16'd6,      4'd4}, // R4 falling, reg 0
    '{1'b1, 2'b01, 1'b0, 1'b0, 3'd2, 16'd6,      4'd4}, // R4 rising, reg 1
    '{1'b0, 2'b01, 1'b0, 1'b0, 3'd1, 16'hBEEF,   4'd5}, // R5 one-sample pulse
    '{1'b1, 2'b10, 1'b0, 1'b0, 3'd1, 16'hBEEF,   4'd5}, // R5 one-sample pulse
    '{1'b0, 2'b11, 1'b0, 1'b0, 3'd3, 16'hBEEF,   4'd8}, // R8 both edges
    '{1'b0, 2'b01, 1'b1, 1'b0, 3'd3, 16'hBEEF,   4'd9}, // R9 compare mode
    '{1'b0, 2'b01, 1'b0, 1'b1, 3'd3, 16'hBEEF,   4'd7}, // R7 external source
    '{1'b1, 2'b01, 1'b0, 1'b1, 3'd2, 16'd0,      4'd7}  // R7 reg 1 unaffected
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk) presc = 1'b1;
    @(negedge clk) presc = 1'b0;
  endtask

  task automatic etick();
    @(negedge clk) ext = 1'b1;
    @(negedge clk) ext = 1'b0;
  endtask

  task automatic wr(input logic ch, input logic [15:0] d);
    @(negedge clk) begin wr_en = 1'b1; wr_sel = ch; wr_data = d; end
    @(negedge clk) wr_en = 1'b0;
  endtask

  task automatic restart();
    @(negedge clk) run = 1'b0;
    @(negedge clk) run = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 cnt", cnt, 0);
    chk("R1 regs", regs, 0);
    chk("R1 irq", irq, 0);

    // R3 counting and source selection
    run = 1'b1;
    repeat (4) tick();
    chk("R3 presc count", cnt, 4);
    etick();
    chk("R3 ext ignored", cnt, 4);
    src_ext = 1'b1;
    repeat (2) etick();
    chk("R3 ext count", cnt, 6);
    tick();
    chk("R3 presc ignored", cnt, 6);
    src_ext = 1'b0;

    // Capture vector table
    for (int i = 0; i < NV; i++) begin
      vec_t v;
      logic idle;
      logic [15:0] act;
      v = VECS[i];
      @(negedge clk) begin
        run = 1'b0; src_ext = v.ext; clr_en = 1'b0;
        cmp_mode = '0; cmp_mode[v.ch] = v.cmp;
        edge_sel = '0; edge_sel[v.ch*2 +: 2] = v.edg;
        idle = (v.edg == 2'b10);
        trig = '0; trig[v.ch] = idle;
      end
      wr(v.ch, 16'hBEEF);
      @(negedge clk) run = 1'b1;
      repeat (5) tick();
      trig[v.ch] = ~idle;
      repeat (int'(v.plen)) tick();
      trig[v.ch] = idle;
      repeat (3) tick();
      act = v.ch ? regs[31:16] : regs[15:0];
      chk($sformatf("R%0d vector %0d", v.req, i), act, v.expv);
    end

    // R6 interrupt one tick after the accepting tick
    @(negedge clk) begin
      src_ext = 0; cmp_mode = 0; edge_sel = 4'b0001; trig = 0;
    end
    repeat (3) tick();
    restart();
    repeat (2) tick();
    trig[0] = 1'b1;
    tick();
    tick();
    chk("R6 no irq on latch tick", irq, 0);
    chk("R4 latched count", regs[15:0], 3);
    @(negedge clk);
    @(negedge clk);
    chk("R6 no irq between ticks", irq, 0);
    tick();
    chk("R6 irq next tick", irq, 2'b01);
    @(negedge clk);
    chk("R6 irq one cycle", irq, 0);
    trig = 0;

    // R10 / R11 compare with clear on register 0
    @(negedge clk) begin edge_sel = 0; cmp_mode = 2'b01; clr_en = 1'b1; end
    wr(1'b0, 16'd3);
    restart();
    repeat (3) tick();
    chk("R10 count before match", cnt, 3);
    tick();
    chk("R11 clear on match", cnt, 0);
    chk("R10 match irq", irq, 2'b01);
    @(negedge clk);
    chk("R10 irq one cycle", irq, 0);

    // R10 compare without clear
    clr_en = 1'b0;
    restart();
    repeat (4) tick();
    chk("R10 no clear count", cnt, 4);
    chk("R10 irq no clear", irq, 2'b01);

    // R11 register 1 match never clears
    @(negedge clk) begin cmp_mode = 2'b10; clr_en = 1'b1; end
    wr(1'b1, 16'd2);
    restart();
    repeat (3) tick();
    chk("R11 reg1 no clear", cnt, 3);
    chk("R10 reg1 irq", irq, 2'b10);

    // R12 write wins over a same-cycle capture on register 1
    @(negedge clk) begin cmp_mode = 0; clr_en = 0; edge_sel = 4'b0100; trig = 0; end
    repeat (3) tick();
    restart();
    trig[1] = 1'b1;
    tick();
    @(negedge clk) begin presc = 1'b1; wr_en = 1'b1; wr_sel = 1'b1; wr_data = 16'h1234; end
    @(negedge clk) begin presc = 1'b0; wr_en = 1'b0; end
    chk("R12 write over capture", regs[31:16], 16'h1234);

    // R2 stop clears counter, keeps registers
    repeat (2) tick();
    @(negedge clk) run = 1'b0;
    @(negedge clk);
    chk("R2 stop count", cnt, 0);
    chk("R2 regs kept", regs[31:16], 16'h1234);
    tick();
    chk("R2 hold while stopped", cnt, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule